// File: doc/BRIEF.md
# Handshaked Parallel Sample Output Port

This block moves receiver sample words off chip over a 16-bit parallel bus. A word source inside the chip hands over complete groups: an I sample, a Q sample and a 12-bit signal-strength (RSSI) value, tagged with the gain-control source (A or B) they belong to. The port keeps a small buffer of such groups. It sends each group as three bus words in the order I, Q, gain. Each word carries a 2-bit channel code and an I-phase flag, so the receiver knows what it holds.

Transfer is paced by a request/acknowledge handshake timed by a port clock. Request is raised on a rising port-clock edge while any word is pending. The far end answers with acknowledge, which the port samples on the falling edge. On the next rising edge the next word goes onto the bus. The port clock is either supplied from outside (slave) or produced by dividing the core clock by 1, 2, 4 or 8 (master). In slave mode the external clock is brought into the core domain through a two-flop synchroniser.

Top module: `sample_out_port`

## Requirements
- R1: With `master_i` high, `pclk_oe_o` is high and `pclk_o` runs with a period of 2^`div_sel_i` core clock cycles (`div_sel_i` = 0, 1, 2, 3 gives division by 1, 2, 4, 8).
- R2: While reset is asserted, and whenever `master_i` is low, `pclk_oe_o` is low and `pclk_o` is driven low, so the port clock pin is never driven in slave mode.
- R3: `req_o` changes only on rising port-clock edges. It is high after a rising edge at which at least one word remains pending. It falls on the same rising edge that presents the last pending word.
- R4: `ack_i` is sampled on each falling port-clock edge. A word is presented on the rising edge that follows a high sample. After a low sample, `data_o`, `ch_o` and `iq_o` keep their previous values.
- R5: While `ack_i` stays high, pending words leave on consecutive port-clock cycles with no gap, including across group boundaries.
- R6: Each group leaves as the I word, then the Q word, then the gain word. `ch_o[0]` is the group's source (0 = A, 1 = B). `ch_o[1]` is 0 for I and Q words and 1 for the gain word.
- R7: `iq_o` is high exactly while an I word is on `data_o`.
- R8: The gain word carries the 12-bit RSSI value in `data_o[11:0]`, with `data_o[15:12]` zero.
- R9: The buffer holds `GRP_DEPTH` (default 2) groups. A group offered with `grp_valid_i` while the buffer is full, and no group leaves on that core edge, is dropped and never appears on the bus. The drop sets `ovf_o`, which stays high until reset.
- R10: In slave mode, all handshake timing follows the edges of `pclk_i`, given a core clock of at least four times the port clock.
- R11: After reset, `req_o`, `data_o`, `ch_o`, `iq_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = port clock generated here, 0 = port clock from `pclk_i` |
| div_sel_i | input | 2 | Master-mode divisor select, division by 2^value |
| pclk_i | input | 1 | External port clock used in slave mode |
| pclk_o | output | 1 | Generated port clock in master mode, low otherwise |
| pclk_oe_o | output | 1 | Output enable for the port clock pin |
| ack_i | input | 1 | Acknowledge from the receiving side |
| grp_valid_i | input | 1 | One-cycle strobe offering a group |
| grp_src_i | input | 1 | Gain-control source of the group (0 = A, 1 = B) |
| grp_i_i | input | 16 | I sample of the group |
| grp_q_i | input | 16 | Q sample of the group |
| grp_rssi_i | input | 12 | RSSI value of the group |
| req_o | output | 1 | Request: words pending |
| data_o | output | 16 | Parallel output word |
| ch_o | output | 2 | Channel code: bit 0 source, bit 1 gain-word flag |
| iq_o | output | 1 | High while an I word is on the bus |
| ovf_o | output | 1 | Sticky flag: a group was dropped |

## Verification
The same handshake script runs in master mode at all four divisors and in slave mode, so that edge-placement faults in the divider or the synchroniser show up as words early, late or missing. The script holds acknowledge low with a group pending, which separates request timing from shifting. It then holds acknowledge high across two back-to-back groups to expose gaps and ordering faults at group boundaries. Three groups offered with acknowledge low force a drop, which checks the sticky flag and that the dropped group never reaches the bus. Finally, a toggling acknowledge checks that every low sample freezes the bus.

// File: rtl/spo_pkg.sv
package spo_pkg;
  localparam int DATA_W = 16;
  localparam int RSSI_W = 12;

  typedef struct packed {
    logic              src;
    logic [DATA_W-1:0] i_w;
    logic [DATA_W-1:0] q_w;
    logic [RSSI_W-1:0] rssi;
  } grp_t;

  typedef enum logic [1:0] {
    W_I = 2'd0,
    W_Q = 2'd1,
    W_G = 2'd2
  } word_e;
endpackage

// File: rtl/spo_clkgen.sv
module spo_clkgen #(
  parameter int DIV_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             pclk_i,
  output logic             pclk_o,
  output logic             pclk_oe_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             both_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W:0]   n_val, half;
  logic [CNT_W:0]   lim_w;
  logic [CNT_W-1:0] lim, cnt_q, cnt_nxt;
  logic             pclk_q, oe_q;
  logic             m_rise, m_fall, s_rise, s_fall, div1;
  logic [SYNC_N:0]  sync_q;

  always_comb begin
    n_val   = (CNT_W+1)'(1) << div_sel_i;
    half    = n_val >> 1;
    lim_w   = n_val - (CNT_W+1)'(1);
    lim     = lim_w[CNT_W-1:0];
    div1    = (div_sel_i == '0);
    cnt_nxt = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    m_rise  = (cnt_q == lim);
    m_fall  = div1 || ({1'b0, cnt_q} == (half - (CNT_W+1)'(1)));
    s_rise  = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    s_fall  = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
      oe_q   <= 1'b0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      pclk_q <= ({1'b0, cnt_nxt} < half);
      oe_q   <= master_i;
      sync_q <= {sync_q[SYNC_N-1:0], pclk_i};
    end
  end

  // divide-by-one forwards the core clock itself
  assign pclk_o    = oe_q ? (div1 ? clk_i : pclk_q) : 1'b0;
  assign pclk_oe_o = oe_q;
  assign rise_o    = master_i ? m_rise : s_rise;
  assign fall_o    = master_i ? m_fall : s_fall;
  assign both_o    = master_i && div1;

  // R1: with a divisor above one, rising strobes are never back to back
  a_r1_rise_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !div1 && rise_o) |=> (!rise_o || !$stable(div_sel_i) || !$stable(master_i)));

  // R10: a slave rising strobe is followed by a quiet cycle
  a_r10_slave_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && rise_o) |=> (!rise_o || !$stable(master_i)));
endmodule

// File: rtl/spo_grp_fifo.sv
module spo_grp_fifo
  import spo_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  grp_t             grp_i,
  input  logic             pop_i,
  output grp_t             head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  grp_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             accept, ovf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    accept  = push_i && ((cnt_q != CNT_W'(DEPTH)) || pop_i);
    cnt_nxt = cnt_q + CNT_W'(accept) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (accept) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      if (push_i && !accept) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_q] <= grp_i;
  end

  assign head_o    = mem[rd_q];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_nxt;
  assign ovf_o     = ovf_q;

  // R9
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/spo_shifter.sv
module spo_shifter
  import spo_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              both_i,
  input  logic              ack_i,
  input  grp_t              head_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  output logic              pop_o,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        ch_o,
  output logic              iq_o
);
  word_e             widx_q;
  logic              ack_q, ack_use, shift, req_q, iq_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        ch_q;

  // at divide-by-one the falling edge falls inside the same core cycle
  assign ack_use = both_i ? ack_i : ack_q;
  assign shift   = rise_i && ack_use && (cnt_i != '0);
  assign pop_o   = shift && (widx_q == W_G);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= W_I;
      ack_q  <= 1'b0;
      req_q  <= 1'b0;
      data_q <= '0;
      ch_q   <= '0;
      iq_q   <= 1'b0;
    end else begin
      if (fall_i) ack_q <= ack_i;
      if (rise_i) req_q <= (cnt_nxt_i != '0);
      if (shift) begin
        unique case (widx_q)
          W_I: begin
            data_q <= head_i.i_w;
            ch_q   <= {1'b0, head_i.src};
            iq_q   <= 1'b1;
            widx_q <= W_Q;
          end
          W_Q: begin
            data_q <= head_i.q_w;
            ch_q   <= {1'b0, head_i.src};
            iq_q   <= 1'b0;
            widx_q <= W_G;
          end
          default: begin
            data_q <= {{(DATA_W-RSSI_W){1'b0}}, head_i.rssi};
            ch_q   <= {1'b1, head_i.src};
            iq_q   <= 1'b0;
            widx_q <= W_I;
          end
        endcase
      end
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;
  assign ch_o   = ch_q;
  assign iq_o   = iq_q;

  // R4: bus only moves on a rising port edge
  a_r4_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> ($stable(data_o) && $stable(ch_o) && $stable(iq_o)));
  // R3
  a_r3_req_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(req_o));
  // R7
  a_r7_iq_not_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_o |-> !ch_o[1]);
  // R8
  a_r8_rssi_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_o[1] |-> (data_o[DATA_W-1:RSSI_W] == '0));
endmodule

// File: rtl/sample_out_port.sv
module sample_out_port
  import spo_pkg::*;
#(
  parameter int DIV_W     = 2,
  parameter int GRP_DEPTH = 2,
  parameter int SYNC_N    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              pclk_i,
  output logic              pclk_o,
  output logic              pclk_oe_o,
  input  logic              ack_i,
  input  logic              grp_valid_i,
  input  logic              grp_src_i,
  input  logic [DATA_W-1:0] grp_i_i,
  input  logic [DATA_W-1:0] grp_q_i,
  input  logic [RSSI_W-1:0] grp_rssi_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        ch_o,
  output logic              iq_o,
  output logic              ovf_o
);
  localparam int CNT_W = $clog2(GRP_DEPTH + 1);

  logic             rise, fall, both, pop;
  grp_t             grp_in, head;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign grp_in = '{src: grp_src_i, i_w: grp_i_i, q_w: grp_q_i, rssi: grp_rssi_i};

  spo_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk_i, .rst_ni, .master_i, .div_sel_i, .pclk_i,
    .pclk_o, .pclk_oe_o,
    .rise_o(rise), .fall_o(fall), .both_o(both)
  );

  spo_grp_fifo #(.DEPTH(GRP_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(grp_valid_i), .grp_i(grp_in), .pop_i(pop),
    .head_o(head), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .ovf_o
  );

  spo_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .both_i(both), .ack_i,
    .head_i(head), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
    .pop_o(pop), .req_o, .data_o, .ch_o, .iq_o
  );

  // R2
  a_r2_slave_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !pclk_oe_o);
endmodule

// File: tb/tb_sample_out_port.sv
module tb_sample_out_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        master_i = 1'b0;
  logic [1:0]  div_sel_i = 2'd0;
  logic        pclk_i = 1'b0;
  logic        pclk_o, pclk_oe_o;
  logic        ack_i = 1'b0, grp_valid_i = 1'b0, grp_src_i = 1'b0;
  logic [15:0] grp_i_i = '0, grp_q_i = '0;
  logic [11:0] grp_rssi_i = '0;
  logic        req_o, iq_o, ovf_o;
  logic [15:0] data_o;
  logic [1:0]  ch_o;

  sample_out_port dut (
    .clk_i, .rst_ni, .master_i, .div_sel_i, .pclk_i, .pclk_o, .pclk_oe_o,
    .ack_i, .grp_valid_i, .grp_src_i, .grp_i_i, .grp_q_i, .grp_rssi_i,
    .req_o, .data_o, .ch_o, .iq_o, .ovf_o
  );

  int    checks = 0, errors = 0, gid = 0;
  bit    slave_on = 1'b0, n1 = 1'b0, is_master = 1'b0;
  string cfg = "";

  // reference model state
  logic [44:0] mq[$];
  int          widx = 0;
  bit          ack_prev = 1'b0, pend_v = 1'b0;
  logic [44:0] pend_g = '0;
  logic [15:0] e_data = '0;
  logic [1:0]  e_ch = '0;
  bit          e_iq = 1'b0, e_req = 1'b0, e_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    forever begin
      repeat (6) @(posedge clk_i);
      #2;
      if (slave_on) pclk_i = ~pclk_i;
      else pclk_i = 1'b0;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cfg, tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    if (is_master) @(posedge pclk_o);
    else begin
      @(posedge pclk_i);
      repeat (4) @(posedge clk_i);
    end
    #1;
  endtask

  task automatic wait_fall();
    if (is_master) @(negedge pclk_o);
    else begin
      @(negedge pclk_i);
      repeat (4) @(posedge clk_i);
    end
    #1;
  endtask

  task automatic model_add(input logic [44:0] g);
    if (mq.size() >= DEPTH) e_ovf = 1'b1;
    else mq.push_back(g);
  endtask

  task automatic model_rise();
    if (ack_prev && mq.size() > 0) begin
      case (widx)
        0: begin e_data = mq[0][43:28]; e_ch = {1'b0, mq[0][44]}; e_iq = 1'b1; end
        1: begin e_data = mq[0][27:12]; e_ch = {1'b0, mq[0][44]}; e_iq = 1'b0; end
        default: begin e_data = {4'h0, mq[0][11:0]}; e_ch = {1'b1, mq[0][44]}; e_iq = 1'b0; end
      endcase
      widx++;
      if (widx == 3) begin
        widx = 0;
        void'(mq.pop_front());
      end
    end
    if (pend_v) begin
      model_add(pend_g);
      pend_v = 1'b0;
    end
    e_req = (mq.size() != 0);
  endtask

  task automatic step(input bit ack, input bit push, input bit src);
    logic [44:0] g;
    wait_rise();
    model_rise();
    ack_i = ack;
    ack_prev = ack;
    if (push) begin
      gid++;
      g = {src, 16'hA000 | 16'(gid), 16'h5000 | 16'(gid), 12'hF00 | 12'(gid & 8'hFF)};
      grp_src_i   = g[44];
      grp_i_i     = g[43:28];
      grp_q_i     = g[27:12];
      grp_rssi_i  = g[11:0];
      grp_valid_i = 1'b1;
      fork
        begin
          @(posedge clk_i);
          grp_valid_i <= 1'b0;
        end
      join_none
      if (n1) begin
        pend_v = 1'b1;
        pend_g = g;
      end else model_add(g);
    end
    wait_fall();
    chk("R4/R5/R6 data", data_o, e_data);
    chk("R6 channel", ch_o, e_ch);
    chk("R7 iq flag", iq_o, e_iq);
    chk("R3 request", req_o, e_req);
    chk("R9 overflow", ovf_o, e_ovf);
    if (e_ch[1]) chk("R8 rssi upper bits", data_o[15:12], 4'h0);
  endtask

  task automatic do_reset(input bit m, input logic [1:0] d);
    rst_ni = 1'b0;
    master_i = m;
    div_sel_i = d;
    is_master = m;
    slave_on = !m;
    n1 = m && (d == 2'd0);
    ack_i = 1'b0;
    grp_valid_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11 reset req", req_o, 0);
    chk("R11 reset data", data_o, 0);
    chk("R11 reset ch", ch_o, 0);
    chk("R11 reset iq", iq_o, 0);
    chk("R11 reset ovf", ovf_o, 0);
    chk("R2 oe in reset", pclk_oe_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mq.delete();
    widx = 0; ack_prev = 0; pend_v = 0;
    e_data = '0; e_ch = '0; e_iq = 0; e_req = 0; e_ovf = 0;
    repeat (2) @(posedge clk_i);
  endtask

  task automatic port_clock_check(input logic [1:0] d);
    time t0, t1;
    if (is_master) begin
      @(posedge pclk_o); t0 = $time;
      @(posedge pclk_o); t1 = $time;
      chk("R1 period", 32'(t1 - t0), 32'(CLK_PERIOD * (1 << d)));
      chk("R1 oe", pclk_oe_o, 1);
    end else begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk_i);
        chk("R2 slave oe", pclk_oe_o, 0);
        chk("R2 slave pclk", pclk_o, 0);
      end
    end
  endtask

  task automatic scenario();
    repeat (2) step(0, 0, 0);
    // R4: group pending, ack low holds bus, request rises
    step(0, 1, 0);
    repeat (3) step(0, 0, 0);
    // R3/R5: drain, request falls with final word
    repeat (5) step(1, 0, 0);
    // R5: back-to-back groups with ack held
    step(1, 1, 1);
    step(1, 1, 0);
    repeat (7) step(1, 0, 0);
    // R9: third group dropped
    step(0, 1, 0);
    step(0, 1, 1);
    step(0, 1, 0);
    repeat (2) step(0, 0, 0);
    repeat (8) step(1, 0, 0);
    // R4: gapped ack
    step(0, 1, 1);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0);
      step(0, 0, 0);
    end
    step(0, 0, 0);
  endtask

  initial begin
    for (int d = 0; d < 4; d++) begin
      cfg = $sformatf("master div_sel=%0d", d);
      do_reset(1'b1, 2'(d));
      port_clock_check(2'(d));
      scenario();
    end
    cfg = "slave R10";
    do_reset(1'b0, 2'd0);
    port_clock_check(2'd0);
    scenario();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule